// File: doc/BRIEF.md
# Pause Flow-Control Resolver

This block runs once the link is up and works out which direction of PAUSE flow control the MAC should use. A one-cycle `start` pulse makes it latch the requested mode, the strict flag, the duplex input and the forced-link flag. Unless the link was forced, it then reads three PHY registers through a simple read-request/response handshake. It reads the status register twice, then the local advertisement register, then the partner ability register.

It combines the PAUSE and asymmetric-direction bits of both sides with the requested mode, the strict flag and the duplex. From that it resolves a mode and drives two enables, one for transmitting PAUSE frames and one for honouring received ones. Completion is marked by a `done` pulse. A failed read or a malformed request is marked by an `err` pulse, and in that case the enables are left as they were.

Requests follow valid/ready rules. `rd_req_valid` and `rd_req_addr` are held steady until the cycle in which `rd_req_ready` is high, which is the transfer cycle. The responder may stall `rd_req_ready` for any number of cycles. There is no back-pressure on responses. A response (`rd_rsp_valid`) counts only if it arrives in a cycle after the request transfer, and one that arrives while no read is outstanding is ignored.

Top module: `fc_pause_resolver`

## Requirements
- R1: After reset both enables are 0, `fc_mode` is 0, and `rd_req_valid`, `done`, `err` and `busy` are 0.
- R2: While `rd_req_valid` is high and `rd_req_ready` is low, the next cycle keeps `rd_req_valid` high with the same `rd_req_addr`. A stalled responder changes neither the read order nor the result.
- R3: The reads go to address 1, address 1 again, address 4, then address 5. Only the second status value is tested, at bit 5 (autonegotiation complete). If that bit is clear, `done` pulses after exactly two reads and the mode and enables stay unchanged.
- R4: If PAUSE (bit 10) is set in both the local and the partner word, the result is full (3) when the requested mode is full (3) or default (4), and receive-only (1) otherwise.
- R5: Local PAUSE=0, local asymmetric (bit 11)=1, partner PAUSE=1 and partner asymmetric=1 resolve to transmit-only (2).
- R6: Local PAUSE=1, local asymmetric=1, partner PAUSE=0 and partner asymmetric=1 resolve to receive-only (1).
- R7: Every other bit combination resolves to none (0) when the requested mode is none (0) or transmit-only (2), or when `strict_mode` is 1. Otherwise it resolves to receive-only (1).
- R8: When `full_duplex` is 0 at start, the result is none, whatever the bits say.
- R9: The mode codes are 0 none, 1 receive-only, 2 transmit-only, 3 full. Once `done` has pulsed, `tx_fc_en` equals bit 1 of `fc_mode` and `rx_fc_en` equals bit 0.
- R10: When `an_failed` is 1 at start, no read is made. The requested mode (with 4 treated as 3) is applied directly, and `done` pulses.
- R11: A requested mode of 5, 6 or 7 makes `err` pulse. No read is made, and the mode and enables stay unchanged.
- R12: An error response on any read ends the sequence. No further read is made, `err` pulses, and the mode and enables stay unchanged.
- R13: A `start` while `busy` is high is ignored.
- R14: `done` and `err` never pulse together, and the enables change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a resolution pass |
| req_mode | input | 3 | Requested mode: 0..3 as in R9, 4 default, 5..7 invalid |
| strict_mode | input | 1 | Forbid the receive-only fallback |
| an_failed | input | 1 | Link was forced; skip the reads |
| full_duplex | input | 1 | Negotiated duplex, 1 = full |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 5 | PHY register address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 16 | Read response data |
| rd_rsp_err | input | 1 | Read response carries an error |
| tx_fc_en | output | 1 | Transmit PAUSE frames enable |
| rx_fc_en | output | 1 | Honour received PAUSE frames enable |
| fc_mode | output | 2 | Resolved mode currently applied |
| busy | output | 1 | Read sequence in progress |
| done | output | 1 | One-cycle pulse: pass completed |
| err | output | 1 | One-cycle pulse: pass aborted |

## Verification
Three situations are hard to reach from the ports. The first is a status register whose two back-to-back reads disagree. The second is an error that arrives only on a late read. The third is a `start` that lands in the middle of a stalled handshake. The bench drives the read port from a small responder model. For each pass it can be given separate values for each of the four reads, the index of the read that should return an error, and a number of stall cycles before each request is accepted. A second `start` carrying a forced-link, mode-none request is pulsed during a long stall, so that accepting it would visibly change the outcome.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_RX   = 2'd1,
    FC_TX   = 2'd2,
    FC_FULL = 2'd3
  } fc_mode_e;

  localparam logic [2:0] REQ_DEFAULT = 3'd4;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;

  // map the 3-bit request to a mode; default becomes full
  function automatic fc_mode_e fix_request(input logic [2:0] r);
    if (r == REQ_DEFAULT) return FC_FULL;
    return fc_mode_e'(r[1:0]);
  endfunction
endpackage

// File: rtl/fcr_rd_seq.sv
module fcr_rd_seq
  import fcr_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int STAT_ADDR   = 1,
  parameter int ADV_ADDR    = 4,
  parameter int LP_ADDR     = 5,
  parameter int AN_DONE_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_err,
  output logic [DATA_W-1:0] adv_q,
  output logic [DATA_W-1:0] lp_q,
  output logic              fin_ok,
  output logic              fin_incomplete,
  output logic              fin_err
);
  localparam int STEPS = 4;
  localparam int STEP_W = $clog2(STEPS);

  sq_state_e         state_q;
  logic [STEP_W-1:0] step_q;

  always_comb begin
    case (step_q)
      2'd2:    req_addr = ADDR_W'(ADV_ADDR);
      2'd3:    req_addr = ADDR_W'(LP_ADDR);
      default: req_addr = ADDR_W'(STAT_ADDR);
    endcase
  end

  assign req_valid = (state_q == SQ_REQ);
  assign busy      = (state_q != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= SQ_IDLE;
      step_q         <= '0;
      adv_q          <= '0;
      lp_q           <= '0;
      fin_ok         <= 1'b0;
      fin_incomplete <= 1'b0;
      fin_err        <= 1'b0;
    end else begin
      fin_ok         <= 1'b0;
      fin_incomplete <= 1'b0;
      fin_err        <= 1'b0;
      case (state_q)
        SQ_IDLE: if (go) begin
          state_q <= SQ_REQ;
          step_q  <= '0;
        end
        SQ_REQ: if (req_ready) state_q <= SQ_WAIT;
        SQ_WAIT: if (rsp_valid) begin
          if (rsp_err) begin
            fin_err <= 1'b1;
            state_q <= SQ_IDLE;
          end else begin
            case (step_q)
              2'd0: begin
                step_q  <= 2'd1;
                state_q <= SQ_REQ;
              end
              2'd1: begin
                if (!rsp_data[AN_DONE_BIT]) begin
                  fin_incomplete <= 1'b1;
                  state_q        <= SQ_IDLE;
                end else begin
                  step_q  <= 2'd2;
                  state_q <= SQ_REQ;
                end
              end
              2'd2: begin
                adv_q   <= rsp_data;
                step_q  <= 2'd3;
                state_q <= SQ_REQ;
              end
              default: begin
                lp_q    <= rsp_data;
                fin_ok  <= 1'b1;
                state_q <= SQ_IDLE;
              end
            endcase
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcr_resolve.sv
module fcr_resolve
  import fcr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PAUSE_BIT = 10,
  parameter int ASM_BIT   = 11
) (
  input  logic [DATA_W-1:0] adv,
  input  logic [DATA_W-1:0] lp,
  input  fc_mode_e          req,
  input  logic              strict_on,
  input  logic              fdx,
  output fc_mode_e          res
);
  logic lcl_p, lcl_a, ptr_p, ptr_a;
  fc_mode_e neg;

  assign lcl_p = adv[PAUSE_BIT];
  assign lcl_a = adv[ASM_BIT];
  assign ptr_p = lp[PAUSE_BIT];
  assign ptr_a = lp[ASM_BIT];

  always_comb begin
    if (lcl_p && ptr_p)
      neg = (req == FC_FULL) ? FC_FULL : FC_RX;
    else if (!lcl_p && lcl_a && ptr_p && ptr_a)
      neg = FC_TX;
    else if (lcl_p && lcl_a && !ptr_p && ptr_a)
      neg = FC_RX;
    else if (req == FC_NONE || req == FC_TX || strict_on)
      neg = FC_NONE;
    else
      neg = FC_RX;
    res = fdx ? neg : FC_NONE;
  end
endmodule

// File: rtl/fcr_apply.sv
module fcr_apply
  import fcr_pkg::*;
#(
  parameter int DIRS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  fc_mode_e        mode_in,
  output fc_mode_e        mode_q,
  output logic [DIRS-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mode_q <= FC_NONE;
    else if (load) mode_q <= mode_in;
  end

  // bit 0 = receive direction, bit 1 = transmit direction
  for (genvar g = 0; g < DIRS; g++) begin : g_dir
    always_ff @(posedge clk) begin
      if (!rst_n)    en_q[g] <= 1'b0;
      else if (load) en_q[g] <= mode_in[g];
    end
  end
endmodule

// File: rtl/fc_pause_resolver.sv
module fc_pause_resolver
  import fcr_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int STAT_ADDR   = 1,
  parameter int ADV_ADDR    = 4,
  parameter int LP_ADDR     = 5,
  parameter int AN_DONE_BIT = 5,
  parameter int PAUSE_BIT   = 10,
  parameter int ASM_BIT     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        req_mode,
  input  logic              strict_mode,
  input  logic              an_failed,
  input  logic              full_duplex,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              tx_fc_en,
  output logic              rx_fc_en,
  output logic [1:0]        fc_mode,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int DIRS = 2;

  logic              seq_busy, go;
  logic              fin_ok, fin_inc, fin_err;
  logic [DATA_W-1:0] adv_w, lp_w;
  logic              accept, req_ok, forced;
  fc_mode_e          req_fix, req_q, resolved, mode_w, load_mode;
  logic              strict_q, fdx_q, load;
  logic [DIRS-1:0]   en_w;

  assign accept  = start && !seq_busy && !fin_ok && !fin_inc && !fin_err;
  assign req_ok  = (req_mode <= REQ_DEFAULT);
  assign req_fix = fix_request(req_mode);
  assign forced  = accept && req_ok && an_failed;
  assign go      = accept && req_ok && !an_failed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= FC_NONE;
      strict_q <= 1'b0;
      fdx_q    <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (go) begin
        req_q    <= req_fix;
        strict_q <= strict_mode;
        fdx_q    <= full_duplex;
      end
      done <= forced || fin_ok || fin_inc;
      err  <= (accept && !req_ok) || fin_err;
    end
  end

  fcr_rd_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR),
    .ADV_ADDR(ADV_ADDR), .LP_ADDR(LP_ADDR), .AN_DONE_BIT(AN_DONE_BIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(seq_busy),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data), .rsp_err(rd_rsp_err),
    .adv_q(adv_w), .lp_q(lp_w),
    .fin_ok(fin_ok), .fin_incomplete(fin_inc), .fin_err(fin_err)
  );

  fcr_resolve #(
    .DATA_W(DATA_W), .PAUSE_BIT(PAUSE_BIT), .ASM_BIT(ASM_BIT)
  ) u_res (
    .adv(adv_w), .lp(lp_w), .req(req_q), .strict_on(strict_q),
    .fdx(fdx_q), .res(resolved)
  );

  assign load      = forced || fin_ok;
  assign load_mode = fin_ok ? resolved : req_fix;

  fcr_apply #(.DIRS(DIRS)) u_app (
    .clk(clk), .rst_n(rst_n), .load(load), .mode_in(load_mode),
    .mode_q(mode_w), .en_q(en_w)
  );

  assign fc_mode  = mode_w;
  assign rx_fc_en = en_w[0];
  assign tx_fc_en = en_w[1];
  assign busy     = seq_busy;
endmodule

// File: rtl/fcr_checker.sv
module fcr_checker #(
  parameter int ADDR_W    = 5,
  parameter int STAT_ADDR = 1,
  parameter int ADV_ADDR  = 4,
  parameter int LP_ADDR   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              tx_fc_en,
  input logic              rx_fc_en,
  input logic              done,
  input logic              err
);
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  a_r3_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr == ADDR_W'(STAT_ADDR) ||
                      rd_req_addr == ADDR_W'(ADV_ADDR) ||
                      rd_req_addr == ADDR_W'(LP_ADDR)));

  a_r14_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  a_r14_en_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fc_en != $past(tx_fc_en) || rx_fc_en != $past(rx_fc_en)) |-> done);

  a_r12_err_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(tx_fc_en) && $stable(rx_fc_en)));
endmodule

bind fc_pause_resolver fcr_checker #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .ADV_ADDR(ADV_ADDR), .LP_ADDR(LP_ADDR)
) u_fcr_chk (
  .clk(clk), .rst_n(rst_n), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .tx_fc_en(tx_fc_en), .rx_fc_en(rx_fc_en),
  .done(done), .err(err)
);

// File: tb/fc_pause_resolver_test.sv
module fc_pause_resolver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  req_mode = 3'd0;
  logic        strict_mode = 1'b0;
  logic        an_failed = 1'b0;
  logic        full_duplex = 1'b1;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [4:0]  rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [15:0] rd_rsp_data = 16'h0;
  logic        rd_rsp_err = 1'b0;
  logic        tx_fc_en, rx_fc_en, busy, done, err;
  logic [1:0]  fc_mode;

  int checks = 0;
  int errors = 0;

  // responder model configuration
  logic [15:0] m_val[0:3];
  int          m_err_idx = -1;
  int          m_stall = 0;
  int          rd_idx = 0;
  int          stall_cnt = 0;
  logic        pending = 1'b0;
  logic [4:0]  addr_log[0:7];

  logic got_done, got_err;
  int   done_cnt;

  fc_pause_resolver uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_mode(req_mode),
    .strict_mode(strict_mode), .an_failed(an_failed), .full_duplex(full_duplex),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
    .tx_fc_en(tx_fc_en), .rx_fc_en(rx_fc_en), .fc_mode(fc_mode),
    .busy(busy), .done(done), .err(err)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    rd_rsp_valid = 1'b0;
    rd_rsp_err   = 1'b0;
    if (!rst_n) begin
      rd_req_ready = 1'b0;
      pending      = 1'b0;
      stall_cnt    = 0;
    end else if (pending) begin
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = m_val[(rd_idx - 1) % 4];
      rd_rsp_err   = ((rd_idx - 1) == m_err_idx);
      pending      = 1'b0;
    end else if (rd_req_ready) begin
      rd_req_ready = 1'b0;
      pending      = 1'b1;
    end else if (rd_req_valid) begin
      if (stall_cnt < m_stall) stall_cnt++;
      else begin
        stall_cnt    = 0;
        rd_req_ready = 1'b1;
        if (rd_idx < 8) addr_log[rd_idx] = rd_req_addr;
        rd_idx++;
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // pulse start and wait for done or err, counting done pulses
  task automatic run_pass();
    got_done = 1'b0;
    got_err  = 1'b0;
    done_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin got_done = 1'b1; done_cnt++; end
      if (err) got_err = 1'b1;
      if (got_done || got_err) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] word(input logic p, input logic a);
    return (16'(p) << 10) | (16'(a) << 11);
  endfunction

  task automatic set_model(input logic [15:0] s0, input logic [15:0] s1,
                           input logic [15:0] adv, input logic [15:0] lp);
    m_val[0] = s0; m_val[1] = s1; m_val[2] = adv; m_val[3] = lp;
    rd_idx = 0;
  endtask

  task automatic check_mode(input string tag, input int exp);
    chk({tag, " mode"}, int'(fc_mode), exp);
    chk({tag, " tx (R9)"}, int'(tx_fc_en), (exp >> 1) & 1);
    chk({tag, " rx (R9)"}, int'(rx_fc_en), exp & 1);
  endtask

  // full autoneg pass; first status read clear, second set (R3)
  task automatic t_neg(input string tag, input logic [2:0] rq, input logic st,
                       input logic fd, input logic lpz, input logic laz,
                       input logic ppz, input logic paz, input int exp);
    req_mode = rq; strict_mode = st; full_duplex = fd; an_failed = 1'b0;
    set_model(16'h0000, 16'h0020, word(lpz, laz), word(ppz, paz));
    run_pass();
    chk({tag, " done"}, int'(got_done), 1);
    chk({tag, " reads R3"}, rd_idx, 4);
    chk({tag, " order R3"}, int'({addr_log[0], addr_log[1], addr_log[2], addr_log[3]}),
        int'({5'd1, 5'd1, 5'd4, 5'd5}));
    check_mode(tag, exp);
  endtask

  task automatic t_reset();
    chk("R1 tx", int'(tx_fc_en), 0);
    chk("R1 rx", int'(rx_fc_en), 0);
    chk("R1 mode", int'(fc_mode), 0);
    chk("R1 flags", int'({rd_req_valid, done, err, busy}), 0);
  endtask

  task automatic t_incomplete();
    req_mode = 3'd3; strict_mode = 1'b0; full_duplex = 1'b1;
    set_model(16'h0020, 16'h0000, word(1, 1), word(1, 1));
    run_pass();
    chk("R3 incomplete done", int'(got_done), 1);
    chk("R3 incomplete reads", rd_idx, 2);
    check_mode("R3 incomplete keeps", 3);
  endtask

  task automatic t_read_err();
    req_mode = 3'd0;
    set_model(16'h0020, 16'h0020, word(0, 0), word(0, 0));
    m_err_idx = 2;
    run_pass();
    m_err_idx = -1;
    chk("R12 err", int'(got_err), 1);
    chk("R12 no done", int'(got_done), 0);
    chk("R12 reads stop", rd_idx, 3);
    check_mode("R12 keeps", 3);
  endtask

  task automatic t_invalid();
    req_mode = 3'd6;
    set_model(16'h0020, 16'h0020, 16'h0, 16'h0);
    run_pass();
    chk("R11 err", int'(got_err), 1);
    chk("R11 reads", rd_idx, 0);
    check_mode("R11 keeps", 3);
  endtask

  task automatic t_forced();
    req_mode = 3'd2; an_failed = 1'b1;
    set_model(16'h0020, 16'h0020, 16'h0, 16'h0);
    run_pass();
    an_failed = 1'b0;
    chk("R10 done", int'(got_done), 1);
    chk("R10 reads", rd_idx, 0);
    check_mode("R10 forced", 2);
  endtask

  task automatic t_busy_stall();
    req_mode = 3'd3; strict_mode = 1'b0; full_duplex = 1'b1;
    set_model(16'h0020, 16'h0020, word(1, 1), word(0, 1));
    m_stall = 6;
    done_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13 busy", int'(busy), 1);
    req_mode = 3'd0; an_failed = 1'b1; start = 1'b1;
    @(negedge clk) start = 1'b0; an_failed = 1'b0;
    for (int i = 0; i < 150; i++) begin
      if (done) done_cnt++;
      @(negedge clk);
    end
    m_stall = 0;
    chk("R13 one done", done_cnt, 1);
    chk("R2 reads under stall", rd_idx, 4);
    chk("R2 order under stall", int'({addr_log[0], addr_log[1], addr_log[2], addr_log[3]}),
        int'({5'd1, 5'd1, 5'd4, 5'd5}));
    check_mode("R6 R13 result", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_neg("R4 full",       3'd3, 0, 1, 1, 1, 1, 0, 3);
    t_neg("R4 req rx",     3'd1, 0, 1, 1, 0, 1, 1, 1);
    t_neg("R4 default",    3'd4, 0, 1, 1, 0, 1, 0, 3);
    t_neg("R5 tx only",    3'd3, 0, 1, 0, 1, 1, 1, 2);
    t_neg("R6 rx asym",    3'd2, 0, 1, 1, 1, 0, 1, 1);
    t_neg("R7 fallback",   3'd3, 0, 1, 1, 0, 0, 0, 1);
    t_neg("R7 strict",     3'd3, 1, 1, 1, 0, 0, 0, 0);
    t_neg("R7 req tx",     3'd2, 0, 1, 0, 1, 0, 0, 0);
    t_neg("R8 half",       3'd3, 0, 0, 1, 1, 1, 1, 0);
    t_neg("R4 restore",    3'd3, 0, 1, 1, 1, 1, 1, 3);
    t_incomplete();
    t_read_err();
    t_invalid();
    t_forced();
    t_busy_stall();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule